// File: doc/BRIEF.md
# Real-Mode Physical Address Former with Power-On Code Alias

This block turns segmented 16-bit references into 32-bit physical addresses for the front end of a processor that starts in real mode. Each cycle a requester may present an access kind together with the live stack and data segment values, the stack pointer and an instruction-supplied offset. The block holds the code segment and instruction pointer itself and picks the segment and offset that the access kind calls for. A registered address and a valid flag appear one cycle later.

Out of reset the code segment holds F000h and the instruction pointer FFF0h. A power-on alias flag is also set. While the flag is set, code fetches use a fixed high base so that the first fetch lands just below the top of the 4 GB space. The first load of the code segment clears the flag for good. From then on every address is formed the normal real-mode way and stays inside the first megabyte.

Top module: `rmag_top`

## Requirements
- R1: After a synchronous active-low reset `addr_vld_o` is 0, the code segment is F000h, the instruction pointer is FFF0h and the alias is active, so the first code fetch gives FFFFFFF0h.
- R2: A normal address is the segment value shifted left by four bits plus the zero-extended 16-bit offset. Bits 31..20 of the result are zero.
- R3: `req_kind_i` selects the source: 2'b00 is a code fetch (code segment and instruction pointer), 2'b01 is a stack access (`ss_i`, `sp_i`), 2'b10 is a data access (`ds_i`, `data_off_i`). 2'b11 is no access, and `addr_vld_o` stays 0 for it.
- R4: While the alias is active a code fetch gives FFFF0000h plus the instruction pointer. Stack and data accesses are always formed normally.
- R5: Any pulse on `cs_ld_i` loads `cs_val_i` and clears the alias on the same edge, even when the value equals the current one. The alias stays clear until the next reset.
- R6: With the alias clear, the carry out of bit 19 is dropped, so addresses wrap inside the first megabyte.
- R7: A request with `req_vld_i` high and a kind other than 2'b11 gives `addr_vld_o` high on the next cycle. Requests are accepted on back-to-back cycles.
- R8: A request in the same cycle as a code segment or instruction pointer load uses the values held before that load.
- R9: A pulse on `ip_ld_i` loads `ip_val_i` into the instruction pointer and leaves the alias unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld_i | input | 1 | Request strobe |
| req_kind_i | input | 2 | Access kind (see R3) |
| ss_i | input | 16 | Stack segment value |
| ds_i | input | 16 | Data segment value |
| sp_i | input | 16 | Stack pointer |
| data_off_i | input | 16 | Instruction-supplied data offset |
| cs_ld_i | input | 1 | Code segment load pulse |
| cs_val_i | input | 16 | New code segment value |
| ip_ld_i | input | 1 | Instruction pointer load pulse |
| ip_val_i | input | 16 | New instruction pointer value |
| addr_o | output | 32 | Physical address |
| addr_vld_o | output | 1 | Address valid, one cycle after the request |

## Verification
The bench builds the block with its default parameters: 16-bit segments and offsets, a 4-bit segment shift, a 32-bit address, reset values F000h and FFF0h, and alias base FFFF0000h. With these values the fetch at FFFFFFF0h can be reached straight from reset. Segment FFFFh with a large offset carries past bit 19, so the 1 MB wrap can be checked. A reload of the same F000h value shows that it is the load itself, not a change of value, that ends the alias.

// File: rtl/rmag_pkg.sv
// Shared types for the real-mode address former.
// Assumes a two-bit access-kind field on the request port.
package rmag_pkg;

    typedef enum logic [1:0] {
        KIND_CODE  = 2'b00,
        KIND_STACK = 2'b01,
        KIND_DATA  = 2'b10,
        KIND_NONE  = 2'b11
    } acc_kind_e;

endpackage

// File: rtl/rmag_seg_state.sv
// Holds the code segment, the instruction pointer and the power-on alias flag.
// Assumes load inputs are single-cycle pulses. The alias is set only by reset
// and is cleared by any code segment load.
module rmag_seg_state #(
    parameter int          SEG_W    = 16,
    parameter int          OFF_W    = 16,
    parameter logic [15:0] RESET_CS = 16'hF000,
    parameter logic [15:0] RESET_IP = 16'hFFF0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_ld_i,
    input  logic [SEG_W-1:0] cs_val_i,
    input  logic             ip_ld_i,
    input  logic [OFF_W-1:0] ip_val_i,
    output logic [SEG_W-1:0] cs_o,
    output logic [OFF_W-1:0] ip_o,
    output logic             alias_o
);

    logic [SEG_W-1:0] cs_q;
    logic [OFF_W-1:0] ip_q;
    logic             alias_q;

    // Code segment register: reset value or loaded value
    always_ff @(posedge clk) begin
        if (!rst_n)       cs_q <= SEG_W'(RESET_CS);
        else if (cs_ld_i) cs_q <= cs_val_i;
    end

    // Instruction pointer register: reset value or loaded value
    always_ff @(posedge clk) begin
        if (!rst_n)       ip_q <= OFF_W'(RESET_IP);
        else if (ip_ld_i) ip_q <= ip_val_i;
    end

    // Alias flag: set by reset, cleared on the edge that loads the code segment
    always_ff @(posedge clk) begin
        if (!rst_n)       alias_q <= 1'b1;
        else if (cs_ld_i) alias_q <= 1'b0;
    end

    assign cs_o    = cs_q;
    assign ip_o    = ip_q;
    assign alias_o = alias_q;

    AST_ALIAS_CLEARS_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cs_ld_i |=> !alias_o); // R5
    AST_ALIAS_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !alias_o |=> !alias_o); // R5
    AST_CS_TAKES_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cs_ld_i |=> cs_o == $past(cs_val_i)); // R5
    AST_IP_LOAD_KEEPS_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_ld_i && !cs_ld_i) |=> $stable(alias_o)); // R9

endmodule

// File: rtl/rmag_src_sel.sv
// Chooses the segment and offset for a request from its access kind and
// marks whether the power-on alias base applies. Purely combinational
// apart from the clock used by its assertion.
module rmag_src_sel
    import rmag_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld_i,
    input  logic [1:0]       req_kind_i,
    input  logic [SEG_W-1:0] cs_i,
    input  logic [SEG_W-1:0] ss_i,
    input  logic [SEG_W-1:0] ds_i,
    input  logic [OFF_W-1:0] ip_i,
    input  logic [OFF_W-1:0] sp_i,
    input  logic [OFF_W-1:0] data_off_i,
    input  logic             alias_i,
    output logic             fire_o,
    output logic [SEG_W-1:0] seg_o,
    output logic [OFF_W-1:0] off_o,
    output logic             use_alias_o
);

    acc_kind_e kind;
    assign kind = acc_kind_e'(req_kind_i);

    // Segment and offset selection by access kind
    always_comb begin
        fire_o      = 1'b0;
        seg_o       = '0;
        off_o       = '0;
        use_alias_o = 1'b0;
        unique case (kind)
            KIND_CODE: begin
                fire_o      = req_vld_i;
                seg_o       = cs_i;
                off_o       = ip_i;
                use_alias_o = alias_i;
            end
            KIND_STACK: begin
                fire_o = req_vld_i;
                seg_o  = ss_i;
                off_o  = sp_i;
            end
            KIND_DATA: begin
                fire_o = req_vld_i;
                seg_o  = ds_i;
                off_o  = data_off_i;
            end
            default: begin
                fire_o = 1'b0;
            end
        endcase
    end

    AST_ALIAS_CODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && use_alias_o) |-> (req_kind_i == 2'b00)); // R4
    AST_NONE_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind_i == 2'b11) |-> !fire_o); // R3

endmodule

// File: rtl/rmag_addr_form.sv
// Forms the physical address and registers it with its valid flag.
// Normal path: segment shifted by SHIFT bits plus offset, modulo 2^(SEG_W+SHIFT),
// zero-extended. Alias path: full-width ALIAS_BASE plus offset.
module rmag_addr_form #(
    parameter int          SEG_W      = 16,
    parameter int          OFF_W      = 16,
    parameter int          SHIFT      = 4,
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] ALIAS_BASE = 32'hFFFF0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic              use_alias_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_vld_o
);

    localparam int RM_W  = SEG_W + SHIFT;
    localparam int PAD_W = ADDR_W - RM_W;

    logic [RM_W-1:0]   rm_sum;
    logic [ADDR_W-1:0] rm_addr;
    logic [ADDR_W-1:0] alias_addr;
    logic [ADDR_W-1:0] next_addr;
    logic              alias_sel_q;

    // Real-mode sum in RM_W bits, so the carry out of the top bit is dropped
    assign rm_sum  = {seg_i, {SHIFT{1'b0}}} + {{(RM_W-OFF_W){1'b0}}, off_i};

    generate
        if (PAD_W > 0) begin : g_pad
            assign rm_addr = {{PAD_W{1'b0}}, rm_sum};
        end else begin : g_nopad
            assign rm_addr = rm_sum[ADDR_W-1:0];
        end
    endgenerate

    assign alias_addr = ADDR_W'(ALIAS_BASE) + {{(ADDR_W-OFF_W){1'b0}}, off_i};
    assign next_addr  = use_alias_i ? alias_addr : rm_addr;

    // Output register: address held from the last accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o      <= '0;
            alias_sel_q <= 1'b0;
        end else if (fire_i) begin
            addr_o      <= next_addr;
            alias_sel_q <= use_alias_i;
        end
    end

    // Valid flag: one cycle after each accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) addr_vld_o <= 1'b0;
        else        addr_vld_o <= fire_i;
    end

    AST_VALID_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> addr_vld_o); // R7
    AST_NO_VALID_WITHOUT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> !addr_vld_o); // R7
    AST_LOW_MEGABYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld_o && !alias_sel_q) |-> (addr_o[ADDR_W-1:RM_W] == '0)); // R6
    AST_ALIAS_HIGH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld_o && alias_sel_q) |-> (addr_o[ADDR_W-1:OFF_W] == ALIAS_BASE[ADDR_W-1:OFF_W])); // R4

endmodule

// File: rtl/rmag_top.sv
// Real-mode physical address former with a power-on code alias.
// Holds the code segment and instruction pointer; the stack and data
// segments, the stack pointer and the data offset come in live each cycle.
// Assumes ADDR_W > SEG_W + SHIFT > OFF_W.
module rmag_top #(
    parameter int          SEG_W      = 16,
    parameter int          OFF_W      = 16,
    parameter int          SHIFT      = 4,
    parameter int          ADDR_W     = 32,
    parameter logic [15:0] RESET_CS   = 16'hF000,
    parameter logic [15:0] RESET_IP   = 16'hFFF0,
    parameter logic [31:0] ALIAS_BASE = 32'hFFFF0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld_i,
    input  logic [1:0]        req_kind_i,
    input  logic [SEG_W-1:0]  ss_i,
    input  logic [SEG_W-1:0]  ds_i,
    input  logic [OFF_W-1:0]  sp_i,
    input  logic [OFF_W-1:0]  data_off_i,
    input  logic              cs_ld_i,
    input  logic [SEG_W-1:0]  cs_val_i,
    input  logic              ip_ld_i,
    input  logic [OFF_W-1:0]  ip_val_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_vld_o
);

    logic [SEG_W-1:0] cs_w;
    logic [OFF_W-1:0] ip_w;
    logic             alias_w;
    logic             fire_w;
    logic [SEG_W-1:0] seg_w;
    logic [OFF_W-1:0] off_w;
    logic             use_alias_w;

    rmag_seg_state #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .RESET_CS(RESET_CS), .RESET_IP(RESET_IP)
    ) u_state (
        .clk(clk), .rst_n(rst_n),
        .cs_ld_i(cs_ld_i), .cs_val_i(cs_val_i),
        .ip_ld_i(ip_ld_i), .ip_val_i(ip_val_i),
        .cs_o(cs_w), .ip_o(ip_w), .alias_o(alias_w)
    );

    rmag_src_sel #(
        .SEG_W(SEG_W), .OFF_W(OFF_W)
    ) u_sel (
        .clk(clk), .rst_n(rst_n),
        .req_vld_i(req_vld_i), .req_kind_i(req_kind_i),
        .cs_i(cs_w), .ss_i(ss_i), .ds_i(ds_i),
        .ip_i(ip_w), .sp_i(sp_i), .data_off_i(data_off_i),
        .alias_i(alias_w),
        .fire_o(fire_w), .seg_o(seg_w), .off_o(off_w), .use_alias_o(use_alias_w)
    );

    rmag_addr_form #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W),
        .ALIAS_BASE(ALIAS_BASE)
    ) u_form (
        .clk(clk), .rst_n(rst_n),
        .fire_i(fire_w), .seg_i(seg_w), .off_i(off_w), .use_alias_i(use_alias_w),
        .addr_o(addr_o), .addr_vld_o(addr_vld_o)
    );

    AST_RESET_NO_VALID: assert property (@(posedge clk)
        !rst_n |=> !addr_vld_o); // R1

endmodule

// File: tb/rmag_top_bench.sv
module rmag_top_bench;

    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] seg;
        logic [15:0] off;
        logic [31:0] exp;
    } vec_t;

    // Vectors applied after the alias has ended (R2, R3, R6)
    localparam vec_t VECS [8] = '{
        '{2'b00, 16'h1234, 16'h0005, 32'h0001_2345},
        '{2'b01, 16'hFFFF, 16'hFFFF, 32'h0000_FFEF},
        '{2'b10, 16'h0000, 16'h0000, 32'h0000_0000},
        '{2'b10, 16'hA000, 16'h1234, 32'h000A_1234},
        '{2'b01, 16'h8000, 16'h0010, 32'h0008_0010},
        '{2'b00, 16'hF000, 16'hFFF0, 32'h000F_FFF0},
        '{2'b00, 16'hFFFF, 16'h0010, 32'h0000_0000},
        '{2'b10, 16'h0001, 16'hFFFF, 32'h0001_000F}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_vld_i;
    logic [1:0]  req_kind_i;
    logic [15:0] ss_i, ds_i, sp_i, data_off_i;
    logic        cs_ld_i, ip_ld_i;
    logic [15:0] cs_val_i, ip_val_i;
    logic [31:0] addr_o;
    logic        addr_vld_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    rmag_top u_rmag_top (
        .clk(clk), .rst_n(rst_n),
        .req_vld_i(req_vld_i), .req_kind_i(req_kind_i),
        .ss_i(ss_i), .ds_i(ds_i), .sp_i(sp_i), .data_off_i(data_off_i),
        .cs_ld_i(cs_ld_i), .cs_val_i(cs_val_i),
        .ip_ld_i(ip_ld_i), .ip_val_i(ip_val_i),
        .addr_o(addr_o), .addr_vld_o(addr_vld_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        req_vld_i = 1'b0; req_kind_i = 2'b11;
        cs_ld_i = 1'b0; ip_ld_i = 1'b0;
    endtask

    // Drive at negedge, let one posedge pass, return at the next negedge
    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic req(input logic [1:0] k);
        req_vld_i = 1'b1; req_kind_i = k;
    endtask

    task automatic load(input logic do_cs, input logic [15:0] cs,
                        input logic do_ip, input logic [15:0] ip);
        cs_ld_i = do_cs; cs_val_i = cs;
        ip_ld_i = do_ip; ip_val_i = ip;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        ss_i = 16'h0; ds_i = 16'h0; sp_i = 16'h0; data_off_i = 16'h0;
        cs_val_i = 16'h0; ip_val_i = 16'h0;
        do_reset();

        // R1: no valid out of reset
        check("R1 valid after reset", {31'b0, addr_vld_o}, 32'h0);

        // R1/R4: first code fetch through the alias
        req(2'b00); tick();
        check("R1 first fetch", addr_o, 32'hFFFF_FFF0);
        check("R7 valid one cycle later", {31'b0, addr_vld_o}, 32'h1);

        // R4: stack and data stay normal while alias active
        ss_i = 16'hF000; sp_i = 16'h0100; req(2'b01); tick();
        check("R4 stack during alias", addr_o, 32'h000F_0100);
        ds_i = 16'h0040; data_off_i = 16'h0002; req(2'b10); tick();
        check("R4 data during alias", addr_o, 32'h0000_0402);

        // R3: kind 2'b11 gives no valid
        req(2'b11); tick();
        check("R3 none kind no valid", {31'b0, addr_vld_o}, 32'h0);

        // R9: IP load keeps alias
        load(1'b0, 16'h0, 1'b1, 16'hFFF8); tick();
        req(2'b00); tick();
        check("R9 alias after ip load", addr_o, 32'hFFFF_FFF8);

        // R8: request in same cycle as same-value CS load and IP load sees old state
        req(2'b00); load(1'b1, 16'hF000, 1'b1, 16'h0004); tick();
        check("R8 old state used", addr_o, 32'hFFFF_FFF8);

        // R5: same-value load ended the alias; R7 back-to-back
        req(2'b00); @(negedge clk);
        check("R5 alias ended", addr_o, 32'h000F_0004);
        req(2'b01); ss_i = 16'h0100; sp_i = 16'h0001; tick();
        check("R7 back-to-back valid", {31'b0, addr_vld_o}, 32'h1);
        check("R7 back-to-back addr", addr_o, 32'h0000_1001);

        // R5: alias stays clear after later IP loads
        load(1'b0, 16'h0, 1'b1, 16'hFFF0); tick();
        req(2'b00); tick();
        check("R5 alias stays clear", addr_o, 32'h000F_FFF0);

        // Table walk: R2, R3, R6
        for (int i = 0; i < 8; i++) begin
            if (VECS[i].kind == 2'b00) begin
                load(1'b1, VECS[i].seg, 1'b1, VECS[i].off); tick();
            end else if (VECS[i].kind == 2'b01) begin
                ss_i = VECS[i].seg; sp_i = VECS[i].off;
            end else begin
                ds_i = VECS[i].seg; data_off_i = VECS[i].off;
            end
            req(VECS[i].kind); tick();
            check($sformatf("R2 R3 R6 vector %0d", i), addr_o, VECS[i].exp);
        end

        // R1: reset restores the alias
        do_reset();
        check("R1 valid cleared by reset", {31'b0, addr_vld_o}, 32'h0);
        req(2'b00); tick();
        check("R1 alias after second reset", addr_o, 32'hFFFF_FFF0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule